// File: doc/BRIEF.md
# SPI Word Data Path

This block is the data register and shift path of a serial peripheral controller that moves either 8-bit or 16-bit words. The processor side sees a small byte-wide register window: a status byte, an upper data lane and a lower data lane. Writes to the data lanes go straight into the shift register, with no transmit buffer in between. Received words land in a single receive buffer, and the processor reads that buffer, not the live shift register. A transfer-complete flag marks each finished word. An overrun flag marks a word that arrived while the previous one was still unread.

In master role the block makes its own serial clock from the system clock through a fixed divider. A write to the lower lane starts a transfer. In slave role it follows an external serial clock, shifting only while its active-low select is held low. The serial clock idles low. Data goes out most significant bit first, is launched on the leading (rising) serial clock edge and is captured on the trailing (falling) edge.

The transfer sequencer has four states. IDLE: waiting, and data-lane writes load the shift register. In IDLE a lower-lane write in master role, or an asserted select in slave role, moves to LOW. LOW: the serial clock is low and the sequencer waits for the leading edge. That edge launches the next bit and moves to HIGH. HIGH: the serial clock is high and the sequencer waits for the trailing edge. That edge captures a bit and moves back to LOW, or to DONE after the last bit. DONE: lasts one cycle, hands the word to the flag unit and returns to IDLE. In slave role, releasing select during LOW or HIGH moves straight back to IDLE.

Top module: `spi_word_datapath`

## Requirements
- R1: In master role, a write to the lower data lane (address 3) from IDLE starts a transfer. The completion flag (status bit 7) reads 1 exactly 2·N·DIV_HALF+1 clock cycles after the write edge and 0 one cycle earlier, where N is the word length.
- R2: The serial clock idles low. Bits leave most significant bit first, change on the rising serial clock edge and are captured on the falling edge. With the data output looped back to the data input, the received word equals the transmitted one.
- R3: With size16 low, words are 8 bits and use only the lower lane (bit 7 is the MSB). A write to the upper lane (address 2) has no effect, and a read of the upper lane returns 0.
- R4: With size16 high, words are 16 bits. The upper lane (address 2) holds bits 15:8 and the lower lane (address 3) holds bits 7:0, and bit 15 is sent first.
- R5: A data-lane read returns the receive buffer. A word just written into the shift register does not appear there until its transfer completes.
- R6: The completion flag clears only after a status read (address 0) that sees it set, followed by a read or write of either data lane. A data access without that status read leaves the flag set.
- R7: If a transfer completes while the completion flag is still set, the overrun flag (status bit 6) sets, the new word is dropped and the receive buffer keeps the older word.
- R8: The overrun flag clears only after a status read that sees it set, followed by a data-lane access.
- R9: Data-lane writes made while a transfer is in progress do not change the word being shifted.
- R10: In slave role, shifting follows sck_i edges only while ss_n_i is low. Serial clock edges seen while ss_n_i is high have no effect. After 8 or 16 trailing edges (per size16), the received word is buffered and the completion flag sets, and miso_o presents the loaded word MSB first.
- R11: In slave role, raising ss_n_i before the last bit abandons the transfer, and the completion flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1 = master role, 0 = slave role |
| size16 | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (arms flag clearing) |
| cpu_addr | input | 2 | 0 = status, 2 = upper data lane, 3 = lower data lane |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Read data byte, combinational from cpu_addr |
| sck_o | output | 1 | Serial clock out (master role) |
| mosi_o | output | 1 | Serial data out (master role) |
| miso_i | input | 1 | Serial data in (master role) |
| sck_i | input | 1 | Serial clock in (slave role) |
| mosi_i | input | 1 | Serial data in (slave role) |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data out (slave role) |

## Verification
In master role the completion flag is due a fixed 2·N·DIV_HALF+1 cycles after the write edge. The bench counts exactly that many edges and samples one cycle before, where it expects 0, and on the due cycle, where it expects 1. It reads the status byte without the read strobe, so sampling never arms a clear. Slave-side results follow the external clock only after two synchronizer stages and an edge detector, so they are due three system cycles after an sck_i transition. The bench holds each serial half-period for eight cycles and samples miso_o and the flags at the end of that window. All samples are taken one nanosecond after a rising clock edge or at a falling edge, never on the active edge.

// File: rtl/spi_dp_pkg.sv
package spi_dp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } xfer_state_t;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd2;
    localparam logic [1:0] ADDR_LO   = 2'd3;

    localparam int STAT_SPIF_BIT = 7;
    localparam int STAT_OVRF_BIT = 6;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_dp_pkg::*;
#(
    parameter int LANE_W   = 8,
    parameter int DIV_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_en,
    input  logic                size16,
    input  logic                ld_hi,
    input  logic                ld_lo,
    input  logic [LANE_W-1:0]   wbyte,
    input  logic                sck_rise,
    input  logic                sck_fall,
    input  logic                ss_act,
    input  logic                mosi_s,
    input  logic                miso_m,
    output logic                sck_m,
    output logic                tx_bit,
    output logic                done,
    output logic [2*LANE_W-1:0] rx_word
);
    localparam int WORD_W = 2 * LANE_W;
    localparam int CNTW   = $clog2(WORD_W + 1);

    xfer_state_t        state, state_nx;
    logic [WORD_W-1:0]  sreg;
    logic [CNTW-1:0]    bits_done;
    logic [CNTW-1:0]    nbits;
    logic               sck_q, txb_q;
    logic               tick, run;
    logic               lead_ev, trail_ev, abort, start, slv_begin, last;
    logic               top_bit, in_bit;

    assign run = master_en && ((state == ST_LOW) || (state == ST_HIGH));

    spi_sck_divider #(.DIV_HALF(DIV_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    assign nbits     = size16 ? CNTW'(WORD_W) : CNTW'(LANE_W);
    assign top_bit   = size16 ? sreg[WORD_W-1] : sreg[LANE_W-1];
    assign in_bit    = master_en ? miso_m : mosi_s;
    assign lead_ev   = master_en ? tick : sck_rise;
    assign trail_ev  = master_en ? tick : sck_fall;
    assign abort     = !master_en && !ss_act &&
                       ((state == ST_LOW) || (state == ST_HIGH));
    assign start     = master_en && ld_lo && (state == ST_IDLE);
    assign slv_begin = !master_en && ss_act && (state == ST_IDLE);
    assign last      = (bits_done == nbits - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start || slv_begin) state_nx = ST_LOW;
            ST_LOW: begin
                if (abort)        state_nx = ST_IDLE;
                else if (lead_ev) state_nx = ST_HIGH;
            end
            ST_HIGH: begin
                if (abort)         state_nx = ST_IDLE;
                else if (trail_ev) state_nx = last ? ST_DONE : ST_LOW;
            end
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    // datapath and serial outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg      <= '0;
            bits_done <= '0;
            sck_q     <= 1'b0;
            txb_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bits_done <= '0;
                    if (ld_hi) sreg[WORD_W-1:LANE_W] <= wbyte;
                    if (ld_lo) sreg[LANE_W-1:0]      <= wbyte;
                end
                ST_LOW: begin
                    if (!abort && lead_ev) begin
                        sck_q <= master_en;
                        txb_q <= top_bit;
                    end
                end
                ST_HIGH: begin
                    if (abort) begin
                        sck_q <= 1'b0;
                    end else if (trail_ev) begin
                        sck_q     <= 1'b0;
                        sreg      <= {sreg[WORD_W-2:0], in_bit};
                        bits_done <= bits_done + 1'b1;
                    end
                end
                ST_DONE: begin
                    bits_done <= '0;
                end
            endcase
        end
    end

    assign sck_m   = sck_q;
    assign tx_bit  = txb_q;
    assign done    = (state == ST_DONE);
    assign rx_word = size16 ? sreg : {{LANE_W{1'b0}}, sreg[LANE_W-1:0]};

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sck_m); // R2

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOW) && (ld_lo || ld_hi)) |=> $stable(sreg)); // R9

    AST_DESELECT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !ss_act && (state == ST_HIGH)) |=> (state == ST_IDLE)); // R11

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              stat_rd,
    input  logic              data_acc,
    output logic              spif,
    output logic              ovrf,
    output logic [WORD_W-1:0] rx_buf
);
    logic spif_arm, ovrf_arm;
    logic clr_spif, clr_ovrf, overrun;

    assign clr_spif = spif_arm && data_acc;
    assign clr_ovrf = ovrf_arm && data_acc;
    assign overrun  = done && spif && !clr_spif;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spif     <= 1'b0;
            ovrf     <= 1'b0;
            spif_arm <= 1'b0;
            ovrf_arm <= 1'b0;
            rx_buf   <= '0;
        end else begin
            if (done && !overrun) rx_buf <= rx_word;

            if (done)          spif <= 1'b1;
            else if (clr_spif) spif <= 1'b0;

            if (overrun)       ovrf <= 1'b1;
            else if (clr_ovrf) ovrf <= 1'b0;

            if (clr_spif)             spif_arm <= 1'b0;
            else if (stat_rd && spif) spif_arm <= 1'b1;

            if (clr_ovrf)             ovrf_arm <= 1'b0;
            else if (stat_rd && ovrf) ovrf_arm <= 1'b1;
        end
    end

    AST_SPIF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spif); // R1

    AST_OVERRUN_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && spif && !data_acc) |=> (ovrf && $stable(rx_buf))); // R7

    AST_SPIF_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (spif && data_acc && !spif_arm) |=> spif); // R6

    AST_SPIF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (spif_arm && data_acc && !done) |=> !spif); // R6

    AST_OVRF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (ovrf_arm && data_acc && !overrun) |=> !ovrf); // R8

endmodule

// File: rtl/spi_word_datapath.sv
module spi_word_datapath
    import spi_dp_pkg::*;
#(
    parameter int LANE_W      = 8,
    parameter int DIV_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              size16,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_addr,
    input  logic [LANE_W-1:0] cpu_wdata,
    output logic [LANE_W-1:0] cpu_rdata,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              ss_n_i,
    output logic              miso_o
);
    localparam int WORD_W = 2 * LANE_W;

    logic              hit_hi, hit_lo, stat_rd, data_acc;
    logic [2:0]        sync_q;
    logic              sck_s, sck_prev, sck_rise, sck_fall;
    logic              sck_m, tx_bit, done;
    logic [WORD_W-1:0] rx_word, rx_buf;
    logic              spif, ovrf;

    assign hit_hi   = (cpu_addr == ADDR_HI);
    assign hit_lo   = (cpu_addr == ADDR_LO);
    assign stat_rd  = cpu_rd && (cpu_addr == ADDR_STAT);
    assign data_acc = (cpu_wr || cpu_rd) && (hit_hi || hit_lo);

    spi_in_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sck_i, mosi_i, ss_n_i}),
        .q    (sync_q)
    );

    assign sck_s = sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign sck_rise = sck_s && !sck_prev;
    assign sck_fall = !sck_s && sck_prev;

    spi_shift_engine #(
        .LANE_W  (LANE_W),
        .DIV_HALF(DIV_HALF)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_en(master_en),
        .size16   (size16),
        .ld_hi    (cpu_wr && hit_hi && size16),
        .ld_lo    (cpu_wr && hit_lo),
        .wbyte    (cpu_wdata),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .ss_act   (!sync_q[0]),
        .mosi_s   (sync_q[1]),
        .miso_m   (miso_i),
        .sck_m    (sck_m),
        .tx_bit   (tx_bit),
        .done     (done),
        .rx_word  (rx_word)
    );

    spi_flag_unit #(.WORD_W(WORD_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .rx_word (rx_word),
        .stat_rd (stat_rd),
        .data_acc(data_acc),
        .spif    (spif),
        .ovrf    (ovrf),
        .rx_buf  (rx_buf)
    );

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            ADDR_STAT: begin
                cpu_rdata[STAT_SPIF_BIT] = spif;
                cpu_rdata[STAT_OVRF_BIT] = ovrf;
            end
            ADDR_HI: if (size16) cpu_rdata = rx_buf[WORD_W-1:LANE_W];
            ADDR_LO: cpu_rdata = rx_buf[LANE_W-1:0];
            default: cpu_rdata = '0;
        endcase
    end

    assign sck_o  = sck_m;
    assign mosi_o = master_en && tx_bit;
    assign miso_o = !master_en && tx_bit;

endmodule

// File: tb/spi_word_datapath_test.sv
`timescale 1ns/1ps
module spi_word_datapath_test;
    localparam int D = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b1;
    logic       size16 = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       sck_o, mosi_o, miso_i, miso_o;
    logic       sck_i = 1'b0;
    logic       mosi_i = 1'b0;
    logic       ss_n_i = 1'b1;

    int checks = 0;
    int bad = 0;
    logic [15:0] cap = '0;

    always #2 clk = ~clk;

    assign miso_i = mosi_o;

    spi_word_datapath #(.LANE_W(8), .DIV_HALF(D), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .size16(size16),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o)
    );

    always @(negedge sck_o) cap <= {cap[14:0], mosi_o};

    // {size16, word}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 16'h00A5}, {1'b0, 16'h0001}, {1'b0, 16'h0080},
        {1'b1, 16'h1234}, {1'b1, 16'h8001}, {1'b1, 16'hC3E7}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic clear_flags();
        logic [7:0] t;
        cpu_read(2'd0, t);
        cpu_read(2'd3, t);
    endtask

    task automatic slave_edge(input logic b, output logic seen);
        @(negedge clk);
        mosi_i = b; sck_i = 1'b1;
        wait_cycles(8);
        @(negedge clk);
        seen = miso_o;
        sck_i = 1'b0;
        wait_cycles(8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] hi_r;
        logic       s;
        logic [15:0] mis;

        wait_cycles(3);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(2);

        // reset state: flags clear, serial clock low
        peek(2'd0, r);
        check("R6 reset status", {8'h00, r}, 16'h0000);
        check("R2 sck idle after reset", {15'h0, sck_o}, 16'h0000);

        // vector table: master loopback
        for (int i = 0; i < 6; i++) begin
            logic        sz;
            logic [15:0] w;
            int          n;
            sz = VEC[i][16];
            w  = VEC[i][15:0];
            n  = sz ? 16 : 8;
            size16 = sz;
            cpu_write(2'd2, sz ? w[15:8] : 8'hEE);
            cpu_write(2'd3, w[7:0]);
            cpu_addr = 2'd0;
            wait_cycles(2 * n * D);
            #1 check("R1 flag not yet set", {8'h00, cpu_rdata}, 16'h0000);
            @(posedge clk);
            #1 check("R1 flag set on due cycle", {8'h00, cpu_rdata}, 16'h0080);
            check("R2 sck low after transfer", {15'h0, sck_o}, 16'h0000);
            check(sz ? "R4 mosi bit order" : "R2 mosi bit order",
                  sz ? cap : {8'h00, cap[7:0]}, sz ? w : {8'h00, w[7:0]});
            cpu_read(2'd0, r);
            cpu_read(2'd2, hi_r);
            cpu_read(2'd3, r);
            check(sz ? "R4 upper lane" : "R3 upper lane reads 0",
                  {8'h00, hi_r}, sz ? {8'h00, w[15:8]} : 16'h0000);
            check(sz ? "R4 lower lane" : "R3 lower lane", {8'h00, r}, {8'h00, w[7:0]});
            peek(2'd0, r);
            check("R6 flag cleared by status then data", {8'h00, r}, 16'h0000);
        end

        // R5 / R6 / R7 / R8 directed sequence, 8-bit master
        size16 = 1'b0;
        cpu_write(2'd3, 8'h3C);
        wait_cycles(2 * 8 * D + 4);
        cpu_read(2'd3, r);
        peek(2'd0, r);
        check("R6 data access without status read keeps flag", {8'h00, r}, 16'h0080);
        cpu_read(2'd0, r);
        cpu_write(2'd3, 8'h81);
        peek(2'd0, r);
        check("R6 flag cleared after arm", {8'h00, r}, 16'h0000);
        peek(2'd3, r);
        check("R5 read returns buffer, not shift reg", {8'h00, r}, 16'h003C);
        wait_cycles(2 * 8 * D + 4);
        peek(2'd3, r);
        check("R5 buffer updated on completion", {8'h00, r}, 16'h0081);
        cpu_write(2'd3, 8'h42);
        wait_cycles(2 * 8 * D + 4);
        peek(2'd0, r);
        check("R7 overrun flag set", {8'h00, r}, 16'h00C0);
        peek(2'd3, r);
        check("R7 older word kept", {8'h00, r}, 16'h0081);
        cpu_read(2'd3, r);
        peek(2'd0, r);
        check("R8 overrun flag held without status read", {8'h00, r & 8'h40}, 16'h0040);
        cpu_read(2'd0, r);
        cpu_read(2'd3, r);
        peek(2'd0, r);
        check("R8 both flags cleared", {8'h00, r}, 16'h0000);

        // R9: writes during a 16-bit transfer are ignored
        size16 = 1'b1;
        cpu_write(2'd2, 8'h12);
        cpu_write(2'd3, 8'h34);
        wait_cycles(5);
        cpu_write(2'd3, 8'hFF);
        cpu_write(2'd2, 8'hFF);
        wait_cycles(2 * 16 * D + 4);
        cpu_read(2'd0, r);
        cpu_read(2'd2, hi_r);
        cpu_read(2'd3, r);
        check("R9 busy writes ignored", {hi_r, r}, 16'h1234);

        // R10: slave role, 8-bit
        master_en = 1'b0;
        size16 = 1'b0;
        cpu_write(2'd3, 8'hB6);
        for (int k = 0; k < 4; k++) slave_edge(1'b1, s);
        peek(2'd0, r);
        check("R10 no shifting while deselected", {8'h00, r}, 16'h0000);
        @(negedge clk) ss_n_i = 1'b0;
        wait_cycles(8);
        mis = '0;
        for (int k = 7; k >= 0; k--) begin
            logic [7:0] pat;
            pat = 8'h5A;
            slave_edge(pat[k], s);
            mis = {mis[14:0], s};
        end
        check("R10 slave miso stream", mis, 16'h00B6);
        peek(2'd0, r);
        check("R10 slave flag set", {8'h00, r}, 16'h0080);
        peek(2'd3, r);
        check("R10 slave received byte", {8'h00, r}, 16'h005A);
        @(negedge clk) ss_n_i = 1'b1;
        wait_cycles(4);
        clear_flags();

        // R11: deselect mid-transfer, 16-bit
        size16 = 1'b1;
        @(negedge clk) ss_n_i = 1'b0;
        wait_cycles(8);
        for (int k = 0; k < 5; k++) slave_edge(1'b1, s);
        @(negedge clk) ss_n_i = 1'b1;
        wait_cycles(40);
        peek(2'd0, r);
        check("R11 abort leaves flag clear", {8'h00, r}, 16'h0000);
        peek(2'd3, r);
        check("R11 buffer unchanged after abort", {8'h00, r}, 16'h005A);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule